// File: doc/BRIEF.md
# Host Controller Interrupt and Command Status Registers

This block is the slice of a USB host controller's register file that records interrupt events and carries the command status word. Hardware raises single-cycle event pulses; each pulse latches a sticky status flag. Software reads the flags over a small parallel bus addressed by 8-bit command codes, where bit 7 of the code selects a write and bits 6:0 select the register. Software removes flags by writing ones to them. An interrupt line is raised while any latched flag is also enabled and the master enable is on.

The command status word holds a two-bit scheduling-overrun tally that advances on every overrun pulse and wraps, plus a software reset request. Setting the request emits a one-cycle reset pulse to the rest of the controller's registers, clears this slice's flags, enables and tally, and holds a busy flag for a fixed cycle count sized to a 10 µs completion bound. Bus accesses are refused while busy. The request bit drops by itself when the count runs out.

Top module: `hc_irq_regs`

## Requirements
- R1: After power-on reset the status (03h), enable (04h) and command status (02h) reads all return zero, and `irq_o`, `busy_o`, `oper_rst_o` and `bus_refused` are low.
- R2: A pulse on `hw_evt[k]` sets status bit k, read back at bit k of code 03h from the next cycle on; hardware never clears a status bit.
- R3: A write with code 83h clears every status bit whose data bit is 1, leaves bits written 0 unchanged, and never sets a bit.
- R4: When an event pulse and a clearing write hit the same status bit in one cycle, the bit ends set.
- R5: `irq_o` is high exactly while some status bit k and enable bit k are both 1 and the master enable is 1; enables are written with code 84h and read with 04h, event enables in bits NUM_EVT-1:0 and the master enable in bit 31.
- R6: Bits 17:16 of the command status read (02h) hold an overrun tally that adds one on every pulse of `hw_evt[0]`, also when status bit 0 is already set, and wraps from 3 to 0.
- R7: Bits of the enable, status and command status words outside the fields of R5, R2 and R6 read as zero and ignore writes; a write of 82h with data bit 0 low has no effect.
- R8: A write of 82h with data bit 0 high raises `oper_rst_o` for exactly one cycle, clears status, enables and tally, and holds `busy_o` high for exactly RESET_CYCLES cycles (CLK_MHZ × 10), after which command status bit 0 reads zero.
- R9: While `busy_o` is high any request is answered with `bus_refused` high and read data zero, and writes have no effect.
- R10: Event pulses still set status bits while `busy_o` is high.
- R11: Codes other than 02h, 03h, 04h, 82h, 83h and 84h read zero and change nothing; a read returns zero whenever the code has bit 7 set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low power-on reset |
| bus_req | input | 1 | Bus request valid this cycle |
| bus_cmd | input | 8 | Command code: bit 7 write, bits 6:0 register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational, zero when not reading |
| bus_refused | output | 1 | Request rejected because a reset is running |
| hw_evt | input | NUM_EVT | Event pulses; bit 0 is the scheduling overrun |
| irq_o | output | 1 | Interrupt request |
| busy_o | output | 1 | Software reset in progress |
| oper_rst_o | output | 1 | One-cycle reset pulse to other operational registers |

## Verification
A flag that is lost, stuck or cleared by the wrong write shows on the next 03h read and, once enabled with the master bit, on `irq_o` one cycle after the event or write. A tally that skips or saturates appears at bits 17:16 after at most four overrun pulses, since the wrap exposes any off-by-one. A reset sequencer with a wrong count shows as a busy window of the wrong length counted cycle by cycle, and a missed wipe shows on the first reads after busy falls.

// File: rtl/hc_irq_pkg.sv
package hc_irq_pkg;

  localparam int DATA_W     = 32;
  localparam int CNT_LSB    = 16;
  localparam int MASTER_BIT = 31;

  localparam logic [6:0] REG_CMDSTAT = 7'h02;
  localparam logic [6:0] REG_INTSTAT = 7'h03;
  localparam logic [6:0] REG_INTEN   = 7'h04;

  typedef enum logic [1:0] {
    SEL_NONE = 2'd0,
    SEL_CMD  = 2'd1,
    SEL_STAT = 2'd2,
    SEL_EN   = 2'd3
  } reg_sel_e;

  // Sticky flag update: a hardware set always beats a clear.
  function automatic logic w1c_next(input logic cur, input logic set, input logic clr);
    return set | (cur & ~clr);
  endfunction

  // Two-bit tally step that rolls over from 3 to 0.
  function automatic logic [1:0] tally_step(input logic [1:0] cnt);
    return cnt + 2'd1;
  endfunction

  function automatic logic [DATA_W-1:0] pack_cmdstat(input logic [1:0] cnt, input logic req);
    logic [DATA_W-1:0] w;
    w = '0;
    w[CNT_LSB +: 2] = cnt;
    w[0] = req;
    return w;
  endfunction

endpackage

// File: rtl/hc_irq_bus_dec.sv
module hc_irq_bus_dec
  import hc_irq_pkg::*;
(
  input  logic       bus_req,
  input  logic [7:0] bus_cmd,
  input  logic       busy_i,
  output logic       wr_stat_o,
  output logic       wr_en_o,
  output logic       wr_cmd_o,
  output reg_sel_e   rd_sel_o,
  output logic       refused_o
);

  logic     is_wr;
  logic     accept;
  reg_sel_e sel;

  assign is_wr  = bus_cmd[7];
  assign accept = bus_req & ~busy_i;

  always_comb begin
    case (bus_cmd[6:0])
      REG_CMDSTAT: sel = SEL_CMD;
      REG_INTSTAT: sel = SEL_STAT;
      REG_INTEN:   sel = SEL_EN;
      default:     sel = SEL_NONE;
    endcase
  end

  assign wr_stat_o = accept & is_wr & (sel == SEL_STAT);
  assign wr_en_o   = accept & is_wr & (sel == SEL_EN);
  assign wr_cmd_o  = accept & is_wr & (sel == SEL_CMD);
  assign rd_sel_o  = (accept & ~is_wr) ? sel : SEL_NONE;
  assign refused_o = bus_req & busy_i;

endmodule

// File: rtl/hc_irq_status_bank.sv
module hc_irq_status_bank
  import hc_irq_pkg::*;
#(
  parameter int NUM_EVT = 7
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_EVT-1:0] set_i,
  input  logic [NUM_EVT-1:0] clr_i,
  input  logic               wipe_i,
  output logic [NUM_EVT-1:0] stat_o
);

  for (genvar g = 0; g < NUM_EVT; g++) begin : g_flag
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) stat_o[g] <= 1'b0;
      else        stat_o[g] <= w1c_next(stat_o[g], set_i[g], clr_i[g] | wipe_i);
    end
  end

endmodule

// File: rtl/hc_irq_enable_reg.sv
module hc_irq_enable_reg #(
  parameter int NUM_EVT = 7
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr_i,
  input  logic [NUM_EVT-1:0] en_wdata_i,
  input  logic               master_wdata_i,
  input  logic               wipe_i,
  output logic [NUM_EVT-1:0] en_o,
  output logic               master_o
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_o     <= '0;
      master_o <= 1'b0;
    end else if (wipe_i) begin
      en_o     <= '0;
      master_o <= 1'b0;
    end else if (wr_i) begin
      en_o     <= en_wdata_i;
      master_o <= master_wdata_i;
    end
  end

endmodule

// File: rtl/hc_irq_tally.sv
module hc_irq_tally
  import hc_irq_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       inc_i,
  input  logic       wipe_i,
  output logic [1:0] cnt_o
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_o <= 2'd0;
    else if (wipe_i) cnt_o <= inc_i ? 2'd1 : 2'd0;
    else if (inc_i)  cnt_o <= tally_step(cnt_o);
  end

endmodule

// File: rtl/hc_irq_reset_seq.sv
module hc_irq_reset_seq #(
  parameter int CYCLES = 2000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start_i,
  output logic busy_o,
  output logic pulse_o
);

  localparam int CW = $clog2(CYCLES + 1);
  localparam logic [CW-1:0] LAST = CW'(CYCLES - 1);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_o  <= 1'b0;
      pulse_o <= 1'b0;
      cnt     <= '0;
    end else begin
      pulse_o <= start_i;
      if (start_i) begin
        busy_o <= 1'b1;
        cnt    <= '0;
      end else if (busy_o) begin
        if (cnt == LAST) busy_o <= 1'b0;
        else             cnt    <= cnt + 1'b1;
      end
    end
  end

endmodule

// File: rtl/hc_irq_regs.sv
module hc_irq_regs
  import hc_irq_pkg::*;
#(
  parameter int NUM_EVT = 7,
  parameter int SO_BIT  = 0,
  parameter int CLK_MHZ = 200
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               bus_req,
  input  logic [7:0]         bus_cmd,
  input  logic [31:0]        bus_wdata,
  output logic [31:0]        bus_rdata,
  output logic               bus_refused,
  input  logic [NUM_EVT-1:0] hw_evt,
  output logic               irq_o,
  output logic               busy_o,
  output logic               oper_rst_o
);

  localparam int RESET_CYCLES = CLK_MHZ * 10;

  logic               wr_stat, wr_en, wr_cmd;
  reg_sel_e           rd_sel;
  logic               sr_start;
  logic [NUM_EVT-1:0] stat_q;
  logic [NUM_EVT-1:0] en_q;
  logic               master_q;
  logic [1:0]         ovr_cnt;
  logic [NUM_EVT-1:0] clr_mask;
  logic [31:0]        stat_word, en_word;
  logic               unused_wdata;

  assign unused_wdata = ^bus_wdata;

  hc_irq_bus_dec u_dec (
    .bus_req   (bus_req),
    .bus_cmd   (bus_cmd),
    .busy_i    (busy_o),
    .wr_stat_o (wr_stat),
    .wr_en_o   (wr_en),
    .wr_cmd_o  (wr_cmd),
    .rd_sel_o  (rd_sel),
    .refused_o (bus_refused)
  );

  assign sr_start = wr_cmd & bus_wdata[0];
  assign clr_mask = wr_stat ? bus_wdata[NUM_EVT-1:0] : '0;

  hc_irq_status_bank #(.NUM_EVT(NUM_EVT)) u_stat (
    .clk    (clk),
    .rst_n  (rst_n),
    .set_i  (hw_evt),
    .clr_i  (clr_mask),
    .wipe_i (sr_start),
    .stat_o (stat_q)
  );

  hc_irq_enable_reg #(.NUM_EVT(NUM_EVT)) u_en (
    .clk            (clk),
    .rst_n          (rst_n),
    .wr_i           (wr_en),
    .en_wdata_i     (bus_wdata[NUM_EVT-1:0]),
    .master_wdata_i (bus_wdata[MASTER_BIT]),
    .wipe_i         (sr_start),
    .en_o           (en_q),
    .master_o       (master_q)
  );

  hc_irq_tally u_tally (
    .clk    (clk),
    .rst_n  (rst_n),
    .inc_i  (hw_evt[SO_BIT]),
    .wipe_i (sr_start),
    .cnt_o  (ovr_cnt)
  );

  hc_irq_reset_seq #(.CYCLES(RESET_CYCLES)) u_seq (
    .clk     (clk),
    .rst_n   (rst_n),
    .start_i (sr_start),
    .busy_o  (busy_o),
    .pulse_o (oper_rst_o)
  );

  always_comb begin
    stat_word = '0;
    stat_word[NUM_EVT-1:0] = stat_q;
    en_word = '0;
    en_word[NUM_EVT-1:0] = en_q;
    en_word[MASTER_BIT] = master_q;
  end

  always_comb begin
    case (rd_sel)
      SEL_CMD:  bus_rdata = pack_cmdstat(ovr_cnt, busy_o);
      SEL_STAT: bus_rdata = stat_word;
      SEL_EN:   bus_rdata = en_word;
      default:  bus_rdata = '0;
    endcase
  end

  assign irq_o = master_q & (|(stat_q & en_q));

endmodule

// File: rtl/hc_irq_regs_chk.sv
module hc_irq_regs_chk #(
  parameter int NUM_EVT      = 7,
  parameter int SO_BIT       = 0,
  parameter int RESET_CYCLES = 2000
) (
  input logic               clk,
  input logic               rst_n,
  input logic               bus_req,
  input logic [31:0]        bus_rdata,
  input logic               bus_refused,
  input logic [NUM_EVT-1:0] hw_evt,
  input logic               irq_o,
  input logic               busy_o,
  input logic               oper_rst_o,
  input logic [NUM_EVT-1:0] stat_q,
  input logic [NUM_EVT-1:0] en_q,
  input logic               master_q,
  input logic [1:0]         ovr_cnt,
  input logic               sr_start
);

  localparam int RW = $clog2(RESET_CYCLES + 2);

  logic [RW-1:0] run;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      run <= '0;
    else if (busy_o) run <= run + 1'b1;
    else             run <= '0;
  end

  assert_evt_lands_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (|hw_evt) |=> ((stat_q & $past(hw_evt)) == $past(hw_evt)));

  assert_rise_needs_evt_R3: assert property (@(posedge clk) disable iff (!rst_n)
    ((stat_q & ~$past(stat_q)) & ~$past(hw_evt)) == '0);

  assert_irq_needs_master_R5: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o |-> master_q);

  assert_irq_quiet_R5: assert property (@(posedge clk) disable iff (!rst_n)
    ((stat_q & en_q) == '0) |-> !irq_o);

  assert_tally_step_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (hw_evt[SO_BIT] && !sr_start) |=> (ovr_cnt == $past(ovr_cnt) + 2'd1));

  assert_tally_wipe_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (sr_start && !hw_evt[SO_BIT]) |=> (ovr_cnt == 2'd0));

  assert_pulse_single_R8: assert property (@(posedge clk) disable iff (!rst_n)
    oper_rst_o |=> !oper_rst_o);

  assert_busy_len_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy_o) |-> (run == RW'(RESET_CYCLES)));

  assert_busy_bound_R8: assert property (@(posedge clk) disable iff (!rst_n)
    busy_o |-> (run < RW'(RESET_CYCLES)));

  assert_refuse_busy_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_req && busy_o) |-> (bus_refused && bus_rdata == '0));

  assert_no_refuse_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !busy_o |-> !bus_refused);

endmodule

bind hc_irq_regs hc_irq_regs_chk #(
  .NUM_EVT      (NUM_EVT),
  .SO_BIT       (SO_BIT),
  .RESET_CYCLES (RESET_CYCLES)
) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .bus_req     (bus_req),
  .bus_rdata   (bus_rdata),
  .bus_refused (bus_refused),
  .hw_evt      (hw_evt),
  .irq_o       (irq_o),
  .busy_o      (busy_o),
  .oper_rst_o  (oper_rst_o),
  .stat_q      (stat_q),
  .en_q        (en_q),
  .master_q    (master_q),
  .ovr_cnt     (ovr_cnt),
  .sr_start    (sr_start)
);

// File: tb/hc_irq_regs_bench.sv
module hc_irq_regs_bench;

  localparam int NEV  = 7;
  localparam int BUSY = 200 * 10;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic            bus_req = 1'b0;
  logic [7:0]      bus_cmd = 8'h00;
  logic [31:0]     bus_wdata = 32'h0;
  logic [31:0]     bus_rdata;
  logic            bus_refused;
  logic [NEV-1:0]  hw_evt = '0;
  logic            irq_o, busy_o, oper_rst_o;

  int checks = 0;
  int errors = 0;
  int busy_seen = 0;
  int pulse_seen = 0;
  int exp_cnt = 0;

  always #2.5 clk = ~clk;

  hc_irq_regs #(.NUM_EVT(NEV), .SO_BIT(0), .CLK_MHZ(200)) u_hc_irq_regs (
    .clk         (clk),
    .rst_n       (rst_n),
    .bus_req     (bus_req),
    .bus_cmd     (bus_cmd),
    .bus_wdata   (bus_wdata),
    .bus_rdata   (bus_rdata),
    .bus_refused (bus_refused),
    .hw_evt      (hw_evt),
    .irq_o       (irq_o),
    .busy_o      (busy_o),
    .oper_rst_o  (oper_rst_o)
  );

  always @(negedge clk) begin
    if (busy_o) busy_seen++;
    if (oper_rst_o) pulse_seen++;
  end

  task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic bus_write(input logic [7:0] c, input logic [31:0] d);
    @(negedge clk);
    bus_req = 1'b1; bus_cmd = c; bus_wdata = d;
    @(posedge clk); #1;
    bus_req = 1'b0; bus_wdata = '0;
  endtask

  task automatic bus_read(input logic [7:0] c, output logic [31:0] d, output logic r);
    @(negedge clk);
    bus_req = 1'b1; bus_cmd = c; bus_wdata = '0;
    #1;
    d = bus_rdata; r = bus_refused;
    @(posedge clk); #1;
    bus_req = 1'b0;
  endtask

  task automatic pulse_evt(input logic [NEV-1:0] m);
    @(negedge clk);
    hw_evt = m;
    @(posedge clk); #1;
    hw_evt = '0;
    if (m[0]) exp_cnt = (exp_cnt + 1) % 4;
  endtask

  function automatic logic [31:0] cmd_word(input int c);
    return 32'(c % 4) << 16;
  endfunction

  task automatic t_reset;
    logic [31:0] d; logic r;
    bus_read(8'h03, d, r); chk("R1", "status after reset", d, 32'h0);
    bus_read(8'h04, d, r); chk("R1", "enable after reset", d, 32'h0);
    bus_read(8'h02, d, r); chk("R1", "cmdstat after reset", d, 32'h0);
    chk("R1", "flags after reset", {28'h0, irq_o, busy_o, oper_rst_o, r}, 32'h0);
  endtask

  task automatic t_events;
    logic [31:0] d; logic r;
    pulse_evt(7'b0010100);
    bus_read(8'h03, d, r); chk("R2", "status after events", d, 32'h14);
    pulse_evt(7'b1000000);
    bus_read(8'h03, d, r); chk("R2", "status keeps old bits", d, 32'h54);
    @(negedge clk); chk("R5", "irq with nothing enabled", {31'h0, irq_o}, 32'h0);
  endtask

  task automatic t_w1c;
    logic [31:0] d; logic r;
    bus_write(8'h83, 32'h10);
    bus_read(8'h03, d, r); chk("R3", "clear one bit", d, 32'h44);
    bus_write(8'h83, 32'h0);
    bus_read(8'h03, d, r); chk("R3", "write zero keeps", d, 32'h44);
    bus_write(8'h83, 32'h7F);
    bus_read(8'h03, d, r); chk("R3", "clear all, no set", d, 32'h0);
  endtask

  task automatic t_collision;
    logic [31:0] d; logic r;
    pulse_evt(7'b0000100);
    @(negedge clk);
    hw_evt = 7'b0000010; bus_req = 1'b1; bus_cmd = 8'h83; bus_wdata = 32'h06;
    @(posedge clk); #1;
    hw_evt = '0; bus_req = 1'b0; bus_wdata = '0;
    bus_read(8'h03, d, r); chk("R4", "set beats clear", d, 32'h02);
    bus_write(8'h83, 32'h7F);
  endtask

  task automatic t_irq;
    logic [31:0] d; logic r;
    bus_write(8'h84, 32'h08);
    pulse_evt(7'b0001000);
    @(negedge clk); chk("R5", "irq without master", {31'h0, irq_o}, 32'h0);
    bus_write(8'h84, 32'h8000_0008);
    @(negedge clk); chk("R5", "irq with master", {31'h0, irq_o}, 32'h1);
    bus_read(8'h04, d, r); chk("R5", "enable readback", d, 32'h8000_0008);
    bus_write(8'h84, 32'h8000_0004);
    @(negedge clk); chk("R5", "irq with other bit enabled", {31'h0, irq_o}, 32'h0);
    bus_write(8'h84, 32'h8000_0008);
    bus_write(8'h83, 32'h08);
    @(negedge clk); chk("R5", "irq after clear", {31'h0, irq_o}, 32'h0);
  endtask

  task automatic t_reserved;
    logic [31:0] d; logic r;
    bus_write(8'h84, 32'hFFFF_FFFF);
    bus_read(8'h04, d, r); chk("R7", "enable reserved bits", d, 32'h8000_007F);
    pulse_evt(7'b0100000);
    bus_write(8'h83, 32'hFFFF_FF80);
    bus_read(8'h03, d, r); chk("R7", "status reserved write", d, 32'h20);
    bus_write(8'h82, 32'hFFFF_FFFE);
    @(negedge clk); chk("R7", "no busy from bit0 low", {31'h0, busy_o}, 32'h0);
    bus_read(8'h02, d, r); chk("R7", "cmdstat reserved", d, cmd_word(exp_cnt));
    bus_read(8'h05, d, r); chk("R11", "unknown read", d, 32'h0);
    bus_write(8'h85, 32'hFFFF_FFFF);
    bus_write(8'h03, 32'hFFFF_FFFF);
    bus_read(8'h03, d, r); chk("R11", "status after odd codes", d, 32'h20);
    bus_read(8'h83, d, r); chk("R11", "read with write code", d, 32'h0);
    bus_write(8'h83, 32'h7F);
    bus_write(8'h84, 32'h0);
  endtask

  task automatic t_tally;
    logic [31:0] d; logic r;
    bus_read(8'h02, d, r); chk("R6", "tally start", d, cmd_word(exp_cnt));
    pulse_evt(7'b0000001);
    bus_read(8'h02, d, r); chk("R6", "tally one", d, cmd_word(exp_cnt));
    pulse_evt(7'b0000001);
    pulse_evt(7'b0000011);
    bus_read(8'h02, d, r); chk("R6", "tally with flag set", d, cmd_word(exp_cnt));
    pulse_evt(7'b0000001);
    bus_read(8'h02, d, r); chk("R6", "tally wraps", d, cmd_word(exp_cnt));
    pulse_evt(7'b0000001);
    bus_read(8'h02, d, r); chk("R6", "tally after wrap", d, cmd_word(exp_cnt));
    bus_read(8'h03, d, r); chk("R6", "overrun flag", d, 32'h03);
  endtask

  task automatic t_soft;
    logic [31:0] d; logic r;
    bus_write(8'h84, 32'h8000_0003);
    @(negedge clk); chk("R8", "irq before reset", {31'h0, irq_o}, 32'h1);
    busy_seen = 0; pulse_seen = 0;
    bus_write(8'h82, 32'h1);
    @(negedge clk);
    chk("R8", "busy after request", {31'h0, busy_o}, 32'h1);
    chk("R8", "irq after wipe", {31'h0, irq_o}, 32'h0);
    bus_read(8'h03, d, r);
    chk("R9", "refused flag", {31'h0, r}, 32'h1);
    chk("R9", "refused read data", d, 32'h0);
    bus_write(8'h84, 32'h8000_007F);
    bus_write(8'h83, 32'h7F);
    pulse_evt(7'b0100000);
    while (busy_o) @(negedge clk);
    chk("R8", "busy length", 32'(busy_seen), 32'(BUSY));
    chk("R8", "reset pulse count", 32'(pulse_seen), 32'h1);
    exp_cnt = 0;
    bus_read(8'h03, d, r); chk("R10", "event during busy kept", d, 32'h20);
    bus_read(8'h04, d, r); chk("R9", "enable write ignored while busy", d, 32'h0);
    bus_read(8'h02, d, r); chk("R8", "cmdstat after reset", d, 32'h0);
    chk("R9", "no refusal after busy", {31'h0, r}, 32'h0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=timeout expected=completion");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (4) @(posedge clk);
    #1 rst_n = 1'b1;
    t_reset;
    t_events;
    t_w1c;
    t_collision;
    t_irq;
    t_reserved;
    t_tally;
    t_soft;
    repeat (3) @(posedge clk);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule